// File: doc/BRIEF.md
# I2C Event Flag and Status Unit

This block is the attention-and-status stage of a register-driven I2C controller. The byte shifter, the start/stop logic and the address comparator each report bus events on a vector of one-cycle event strobes. When any of these strobes fires while the unit is idle, the unit raises an interrupt flag. One clock later it loads an 8-bit status code that names the event. While the flag is up, the unit also asks the bus pad logic to hold SCL low. This stalls the transfer until the host has served the event.

The host reads the status and then writes a clear strobe. The flag drops on the next edge, and the SCL hold and the status code drop with it. Outside a flagged interval the status output always carries a fixed "nothing to report" code. Software can therefore trust the status only while the flag is up. Events that arrive while the flag is set are not taken in, because the stretched clock keeps the bus from moving.

Top module: `i2c_evs_top`

## Requirements
- R1: When the flag is low and any bit of `evt_i` is high in a cycle, `irq_o` is high from the next clock edge onward.
- R2: `scl_hold_o` is high exactly while `irq_o` is high.
- R3: In the first cycle that `irq_o` is high, `status_o` still shows 8'hF8. From the second cycle on, it shows the event's code.
- R4: The code of event bit i is (i+1)*8. Bit 0 is arbitration lost (8'h08). Bit 1 is start sent (8'h10). Bit 2 is repeated start sent (8'h18). Bit 3 is address byte sent and acknowledged (8'h20). Bit 4 is address byte sent and not acknowledged (8'h28). Bit 5 is addressed by own address (8'h30). Bit 6 is addressed by general call (8'h38). Bit 7 is data byte received (8'h40). The low three bits of every code are zero.
- R5: When several event bits are high in the same cycle, the lowest set bit is reported. Arbitration lost (bit 0) therefore wins over all other events.
- R6: Whenever `irq_o` is low, `status_o` equals 8'hF8.
- R7: A `clr_i` pulse while `irq_o` is high makes `irq_o` and `scl_hold_o` low at the next edge, and `status_o` returns to 8'hF8 at that same edge.
- R8: While `irq_o` is high, `evt_i` is ignored: the flag stays up and the loaded status code does not change.
- R9: A `clr_i` pulse while `irq_o` is low has no effect on any output.
- R10: While `rst` is high, and in the first cycle after reset, `irq_o` and `scl_hold_o` are low and `status_o` is 8'hF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_EV (8) | Bus event strobes, bit index per R4 |
| clr_i | input | 1 | Host flag-clear strobe |
| irq_o | output | 1 | Interrupt flag |
| status_o | output | 8 | Status code, 8'hF8 when nothing to report |
| scl_hold_o | output | 1 | Request to hold SCL low |

## Verification
A flag register stuck or set late shows up at the ports on the edge after an event: `irq_o` and `scl_hold_o` come up late or not at all. A bad latched index or priority choice shows up one cycle later, when `status_o` carries a code other than the lowest set bit's. A status register that loads too early, fails to return to 8'hF8 on clear, or reloads while the flag is held differs from the expected code within one cycle. The bench sweeps every nonzero event pattern and checks each of these cycles.

// File: rtl/i2c_evs_pkg.sv
package i2c_evs_pkg;
  localparam int unsigned STAT_W = 8;
  localparam logic [STAT_W-1:0] IDLE_CODE = 8'hF8;

  // event bit positions; position also sets priority (lower wins)
  localparam int unsigned EV_ARB_LOST   = 0;
  localparam int unsigned EV_START      = 1;
  localparam int unsigned EV_RSTART     = 2;
  localparam int unsigned EV_ADR_ACK    = 3;
  localparam int unsigned EV_ADR_NACK   = 4;
  localparam int unsigned EV_OWN_HIT    = 5;
  localparam int unsigned EV_GCALL_HIT  = 6;
  localparam int unsigned EV_DATA_RX    = 7;

  // status code for an event index: (index + 1) * 8, low 3 bits zero
  function automatic logic [STAT_W-1:0] evt_code(input int unsigned idx);
    return STAT_W'((idx + 1) * 8);
  endfunction
endpackage

// File: rtl/i2c_evs_prio.sv
module i2c_evs_prio #(
  parameter int unsigned NUM_EV = 8,
  localparam int unsigned IDX_W = (NUM_EV > 1) ? $clog2(NUM_EV) : 1
) (
  input  logic [NUM_EV-1:0] req_i,
  output logic              any_o,
  output logic [IDX_W-1:0]  idx_o
);
  // scan from the top so that the lowest set bit is the last written
  always_comb begin
    idx_o = '0;
    for (int i = NUM_EV - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/i2c_evs_flag.sv
module i2c_evs_flag #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] hit_idx_i,
  input  logic             clr_i,
  output logic             flag_o,
  output logic             load_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             clr_take_o
);
  logic accept;

  assign accept     = hit_i && !flag_o;
  assign clr_take_o = clr_i && flag_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      load_o <= 1'b0;
      idx_o  <= '0;
    end else begin
      load_o <= accept;
      if (accept) idx_o <= hit_idx_i;
      if (clr_take_o)  flag_o <= 1'b0;
      else if (accept) flag_o <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_evs_stat.sv
module i2c_evs_stat
  import i2c_evs_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              clr_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [STAT_W-1:0] status_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) status_o <= IDLE_CODE;
    else if (load_i)  status_o <= evt_code(int'(idx_i));
  end
endmodule

// File: rtl/i2c_evs_top.sv
module i2c_evs_top
  import i2c_evs_pkg::*;
#(
  parameter int unsigned NUM_EV = 8,
  localparam int unsigned IDX_W = (NUM_EV > 1) ? $clog2(NUM_EV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] evt_i,
  input  logic              clr_i,
  output logic              irq_o,
  output logic [7:0]        status_o,
  output logic              scl_hold_o
);
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic             flag_q;
  logic             load_q;
  logic [IDX_W-1:0] idx_q;
  logic             clr_take;

  i2c_evs_prio #(.NUM_EV(NUM_EV)) u_prio (
    .req_i (evt_i),
    .any_o (hit),
    .idx_o (hit_idx)
  );

  i2c_evs_flag #(.IDX_W(IDX_W)) u_flag (
    .clk        (clk),
    .rst        (rst),
    .hit_i      (hit),
    .hit_idx_i  (hit_idx),
    .clr_i      (clr_i),
    .flag_o     (flag_q),
    .load_o     (load_q),
    .idx_o      (idx_q),
    .clr_take_o (clr_take)
  );

  i2c_evs_stat #(.IDX_W(IDX_W)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load_q),
    .clr_i    (clr_take),
    .idx_i    (idx_q),
    .status_o (status_o)
  );

  assign irq_o      = flag_q;
  assign scl_hold_o = flag_q;
endmodule

// File: rtl/i2c_evs_chk.sv
module i2c_evs_chk #(
  parameter int unsigned NUM_EV = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_EV-1:0] evt_i,
  input logic              clr_i,
  input logic              irq_o,
  input logic [7:0]        status_o,
  input logic              scl_hold_o
);
  p_flag_set_r1: assert property (@(posedge clk) disable iff (rst)
    (!irq_o && (|evt_i)) |=> irq_o);

  p_hold_tracks_r2: assert property (@(posedge clk) disable iff (rst)
    scl_hold_o == irq_o);

  p_first_cycle_idle_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> status_o == 8'hF8);

  p_code_loaded_r3: assert property (@(posedge clk) disable iff (rst)
    (irq_o && $past(irq_o)) |-> status_o != 8'hF8);

  p_low_bits_r4: assert property (@(posedge clk) disable iff (rst)
    status_o[2:0] == 3'b000);

  p_idle_code_r6: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> status_o == 8'hF8);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_o && clr_i) |=> !irq_o);

  p_held_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_o && $past(irq_o) && !clr_i) |=> (irq_o && $stable(status_o)));

  p_idle_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (!irq_o && clr_i && !(|evt_i)) |=> !irq_o);
endmodule

bind i2c_evs_top i2c_evs_chk #(.NUM_EV(NUM_EV)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .evt_i      (evt_i),
  .clr_i      (clr_i),
  .irq_o      (irq_o),
  .status_o   (status_o),
  .scl_hold_o (scl_hold_o)
);

// File: tb/sim_i2c_evs_top.sv
`timescale 1ns/1ps
module sim_i2c_evs_top;
  localparam int NEV = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NEV-1:0] evt = '0;
  logic           clr = 1'b0;
  logic           irq;
  logic [7:0]     stat;
  logic           hold;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  i2c_evs_top #(.NUM_EV(NEV)) u0 (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (evt),
    .clr_i      (clr),
    .irq_o      (irq),
    .status_o   (stat),
    .scl_hold_o (hold)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_code(input logic [NEV-1:0] p);
    for (int i = 0; i < NEV; i++)
      if (p[i]) return 8'((i + 1) * 8);
    return 8'hF8;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    // R10: outputs during reset
    chk("R10 irq in reset", {7'b0, irq}, 8'h00);
    chk("R10 status in reset", stat, 8'hF8);
    step();
    rst = 1'b0;
    step();
    chk("R10 irq after reset", {7'b0, irq}, 8'h00);
    chk("R10 hold after reset", {7'b0, hold}, 8'h00);
    chk("R10 status after reset", stat, 8'hF8);

    // R9: clear while idle
    clr = 1'b1;
    step();
    clr = 1'b0;
    chk("R9 irq after idle clear", {7'b0, irq}, 8'h00);
    chk("R9 status after idle clear", stat, 8'hF8);

    for (int p = 1; p < (1 << NEV); p++) begin
      logic [7:0] ec;
      ec  = exp_code(NEV'(p));
      evt = NEV'(p);
      step();
      // first flagged cycle: R1, R2, R3
      chk("R1 flag set", {7'b0, irq}, 8'h01);
      chk("R2 hold with flag", {7'b0, hold}, 8'h01);
      chk("R3 status lag", stat, 8'hF8);
      evt = ~NEV'(p);      // R8: must be ignored
      step();
      chk("R4 R5 status code", stat, ec);
      chk("R4 low bits zero", {5'b0, stat[2:0]}, 8'h00);
      evt = NEV'(p);
      step();
      evt = '0;
      chk("R8 flag kept", {7'b0, irq}, 8'h01);
      chk("R8 status kept", stat, ec);
      clr = 1'b1;
      step();
      clr = 1'b0;
      chk("R7 flag cleared", {7'b0, irq}, 8'h00);
      chk("R7 hold released", {7'b0, hold}, 8'h00);
      chk("R6 idle status", stat, 8'hF8);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule